// File: doc/BRIEF.md
# Strobe-Clocked Byte Link Endpoint

This block is the fabric-side end of a full-duplex byte link to a host processor. The host generates the link's timing in software: it toggles a slow strobe line, and each rising edge of that strobe marks a moment at which data on the link ports is meant to be taken. There are two separate 8-bit data paths, one in each direction. Each direction has its own valid/ready pair, so an inbound byte and an outbound byte can move on the same strobe edge. A host-driven reset line clears only this link logic.

All host-driven inputs are brought into the fast fabric clock domain through flop synchronisers, and the strobe is edge-detected there. On the fabric side, inbound bytes are offered to user logic as a valid/ready stream. User logic hands outbound bytes in through a second valid/ready stream. Each direction holds one byte, so the user side and the host side can each run at their own pace without losing data.

Top module: `hostByteLink`

## Requirements
- R1: While the fabric reset `rstN` is low, and after it is released with all host inputs low, `rxValid` and `fpgaValid` are 0 and both `fpgaReady` and `txReady` are 1.
- R2: An inbound byte is captured on a rising edge of `linkStrobe` when `hostValid` is high and `fpgaReady` is high. `rxValid` rises and `rxData` shows the byte on the third rising `clk` edge after the first `clk` edge that samples the strobe high.
- R3: While a captured byte has not been taken by user logic, `fpgaReady` is 0. Further strobe edges leave `rxData` unchanged.
- R4: A fabric clock edge with `rxValid` and `rxReady` both high empties the inbound holding register. `rxValid` is 0 and `fpgaReady` is 1 from that edge on.
- R5: A strobe rising edge with `hostValid` low captures nothing.
- R6: A fabric clock edge with `txValid` and `txReady` both high loads `txData`. From that edge on, `fpgaValid` is 1, `linkDataOut` shows the byte and `txReady` is 0. While full, `txValid` is ignored and `linkDataOut` holds.
- R7: The outbound byte stays presented until a strobe rising edge sees `hostReady` high. `fpgaValid` then falls, and `txReady` rises, on the third `clk` edge after the first edge that samples the strobe high.
- R8: A strobe rising edge with `hostReady` low leaves `fpgaValid` and `linkDataOut` unchanged.
- R9: Only rising strobe edges act. A strobe held high acts once, and a falling edge acts not at all.
- R10: One strobe rising edge can capture an inbound byte and release an outbound byte together.
- R11: From the second `clk` edge after `linkReset` is sampled high, and for as long as it stays high, `fpgaReady` and `txReady` are 0. From the third edge on, both holding registers are empty (`rxValid` = 0, `fpgaValid` = 0). After `linkReset` is released, both ready outputs return to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rstN | input | 1 | Fabric reset, active low, asynchronous |
| linkStrobe | input | 1 | Host software strobe; its rising edge times each transfer |
| linkReset | input | 1 | Host reset of the link logic, active high |
| hostValid | input | 1 | Host has placed an inbound byte on `linkDataIn` |
| hostReady | input | 1 | Host can accept an outbound byte |
| linkDataIn | input | 8 | Inbound byte from the host |
| fpgaReady | output | 1 | Fabric can accept another inbound byte |
| fpgaValid | output | 1 | An outbound byte is on `linkDataOut` |
| linkDataOut | output | 8 | Outbound byte to the host |
| rxData | output | 8 | Received byte for user logic |
| rxValid | output | 1 | `rxData` holds an unread byte |
| rxReady | input | 1 | User logic takes the received byte |
| txData | input | 8 | Byte from user logic to send |
| txValid | input | 1 | User logic offers `txData` |
| txReady | output | 1 | Outbound register is free to load |

## Verification
Any host-side event (strobe, host valid and ready, link reset) passes two synchroniser flops and an edge register before it acts. An inbound capture or outbound release is therefore due on the third `clk` edge after the strobe is first sampled high. The ready outputs react to link reset one edge earlier than the holding registers do. User-side handshakes take effect on the next edge. The bench drives inputs at falling edges and mirrors these delays in a behavioural model that keeps a short history of the sampled host inputs. It compares every output at each falling edge. Directed checks then sample at the counted edges, including one that confirms the capture is absent after two edges and present after three.

// File: rtl/hostLinkPkg.sv
package hostLinkPkg;

  // Strobes issued by the control unit to the byte datapath each cycle.
  typedef struct packed {
    logic captureIn;   // load synchronised inbound byte
    logic drainIn;     // user logic takes inbound byte
    logic loadOut;     // load user byte for the host
    logic releaseOut;  // host has taken outbound byte
    logic flush;       // link reset held
  } linkCmd_t;

endpackage

// File: rtl/linkSync.sv
module linkSync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stage;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= '0;
        else       stage <= asyncIn;
      end
    end else begin : gChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= '0;
        else       stage <= {stage[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/linkCtrl.sv
module linkCtrl
  import hostLinkPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     strobeS,
  input  logic     hostValidS,
  input  logic     hostReadyS,
  input  logic     linkResetS,
  input  logic     rxReady,
  input  logic     txValid,
  output linkCmd_t cmd,
  output logic     rxFull,
  output logic     outFull,
  output logic     rxValid,
  output logic     fpgaReady,
  output logic     fpgaValid,
  output logic     txReady
);

  logic strobePrev;
  logic strobeRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobePrev <= 1'b0;
    else       strobePrev <= strobeS;
  end

  assign strobeRise = strobeS & ~strobePrev;

  always_comb begin
    cmd            = '0;
    cmd.flush      = linkResetS;
    cmd.captureIn  = !linkResetS && !rxFull && strobeRise && hostValidS;
    cmd.drainIn    = !linkResetS && rxFull && rxReady;
    cmd.loadOut    = !linkResetS && !outFull && txValid;
    cmd.releaseOut = !linkResetS && outFull && strobeRise && hostReadyS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull  <= 1'b0;
      outFull <= 1'b0;
    end else if (cmd.flush) begin
      rxFull  <= 1'b0;
      outFull <= 1'b0;
    end else begin
      if (cmd.captureIn)     rxFull <= 1'b1;
      else if (cmd.drainIn)  rxFull <= 1'b0;
      if (cmd.loadOut)         outFull <= 1'b1;
      else if (cmd.releaseOut) outFull <= 1'b0;
    end
  end

  assign rxValid   = rxFull;
  assign fpgaValid = outFull;
  assign fpgaReady = !rxFull && !linkResetS;
  assign txReady   = !outFull && !linkResetS;

  // R2: a new inbound byte only appears after a strobe rise seen with host valid
  a_r2_capture_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxValid) |-> $past(strobeRise && hostValidS));

  // R3: an unread byte is not lost while user logic stalls
  a_r3_hold_unread: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady && !linkResetS) |=> rxValid);

  // R7: the outbound byte leaves only on a host-ready strobe rise or a link reset
  a_r7_release_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fpgaValid) |-> $past(linkResetS || (strobeRise && hostReadyS)));

  // R9: a strobe held high yields one action only
  a_r9_single_rise: assert property (@(posedge clk) disable iff (!rstN)
    strobeRise |=> !strobeRise);

  // R11: link reset empties both directions
  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    linkResetS |=> (!rxValid && !fpgaValid));

endmodule

// File: rtl/linkData.sv
module linkData
  import hostLinkPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  linkCmd_t          cmd,
  input  logic              rxFull,
  input  logic              outFull,
  input  logic [DATA_W-1:0] linkByteS,
  input  logic [DATA_W-1:0] txData,
  output logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] linkDataOut
);

  logic [DATA_W-1:0] rxByte;
  logic [DATA_W-1:0] outByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      outByte <= '0;
    end else begin
      if (cmd.captureIn) rxByte  <= linkByteS;
      if (cmd.loadOut)   outByte <= txData;
    end
  end

  assign rxData      = rxByte;
  assign linkDataOut = outByte;

  // R3: a held inbound byte is never overwritten
  a_r3_rx_stable: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !cmd.drainIn && !cmd.flush) |=> $stable(rxData));

  // R6: the presented outbound byte stays put until released
  a_r6_out_stable: assert property (@(posedge clk) disable iff (!rstN)
    (outFull && !cmd.releaseOut && !cmd.flush) |=> $stable(linkDataOut));

endmodule

// File: rtl/hostByteLink.sv
module hostByteLink
  import hostLinkPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkStrobe,
  input  logic              linkReset,
  input  logic              hostValid,
  input  logic              hostReady,
  input  logic [DATA_W-1:0] linkDataIn,
  output logic              fpgaReady,
  output logic              fpgaValid,
  output logic [DATA_W-1:0] linkDataOut,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady
);

  localparam int SYNC_W = DATA_W + 4;

  logic [SYNC_W-1:0] syncIn;
  logic [SYNC_W-1:0] syncOut;
  logic              strobeS, hostValidS, hostReadyS, linkResetS;
  logic [DATA_W-1:0] linkByteS;
  linkCmd_t          cmd;
  logic              rxFull, outFull;

  assign syncIn = {linkReset, hostReady, hostValid, linkStrobe, linkDataIn};
  assign {linkResetS, hostReadyS, hostValidS, strobeS, linkByteS} = syncOut;

  linkSync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (syncIn),
    .syncOut (syncOut)
  );

  linkCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .strobeS    (strobeS),
    .hostValidS (hostValidS),
    .hostReadyS (hostReadyS),
    .linkResetS (linkResetS),
    .rxReady    (rxReady),
    .txValid    (txValid),
    .cmd        (cmd),
    .rxFull     (rxFull),
    .outFull    (outFull),
    .rxValid    (rxValid),
    .fpgaReady  (fpgaReady),
    .fpgaValid  (fpgaValid),
    .txReady    (txReady)
  );

  linkData #(.DATA_W(DATA_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .rxFull      (rxFull),
    .outFull     (outFull),
    .linkByteS   (linkByteS),
    .txData      (txData),
    .rxData      (rxData),
    .linkDataOut (linkDataOut)
  );

endmodule

// File: tb/hostByteLink_test.sv
module hostByteLink_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       linkStrobe = 1'b0, linkReset = 1'b0, hostValid = 1'b0, hostReady = 1'b0;
  logic [7:0] linkDataIn = '0;
  logic       fpgaReady, fpgaValid, rxValid, txReady;
  logic [7:0] linkDataOut, rxData;
  logic       rxReady = 1'b0, txValid = 1'b0;
  logic [7:0] txData = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  hostByteLink uut (
    .clk(clk), .rstN(rstN), .linkStrobe(linkStrobe), .linkReset(linkReset),
    .hostValid(hostValid), .hostReady(hostReady), .linkDataIn(linkDataIn),
    .fpgaReady(fpgaReady), .fpgaValid(fpgaValid), .linkDataOut(linkDataOut),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .txData(txData), .txValid(txValid), .txReady(txReady)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: host inputs act two edges after they are sampled,
  // a strobe rise is a change seen between the 2nd and 3rd most recent samples.
  bit [2:0] hS, hV, hR, hL;
  bit [7:0] hD0, hD1;
  bit       mRxFull, mOutFull;
  bit [7:0] mRxByte, mOutByte;

  always @(posedge clk) begin
    if (!rstN) begin
      hS = '0; hV = '0; hR = '0; hL = '0; hD0 = '0; hD1 = '0;
      mRxFull = 0; mOutFull = 0; mRxByte = '0; mOutByte = '0;
    end else begin
      bit rise;
      rise = hS[1] && !hS[2];
      if (hL[1]) begin
        mRxFull = 0; mOutFull = 0;
      end else begin
        if (mRxFull) begin
          if (rxReady) mRxFull = 0;
        end else if (rise && hV[1]) begin
          mRxFull = 1; mRxByte = hD1;
        end
        if (mOutFull) begin
          if (rise && hR[1]) mOutFull = 0;
        end else if (txValid) begin
          mOutFull = 1; mOutByte = txData;
        end
      end
      hS = {hS[1:0], linkStrobe};
      hV = {hV[1:0], hostValid};
      hR = {hR[1:0], hostReady};
      hL = {hL[1:0], linkReset};
      hD1 = hD0; hD0 = linkDataIn;
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN && !done) begin
      check("R2 model rxValid", rxValid, mRxFull);
      if (mRxFull) check("R3 model rxData", rxData, mRxByte);
      check("R3 model fpgaReady", fpgaReady, !mRxFull && !hL[1]);
      check("R6 model fpgaValid", fpgaValid, mOutFull);
      if (mOutFull) check("R6 model linkDataOut", linkDataOut, mOutByte);
      check("R7 model txReady", txReady, !mOutFull && !hL[1]);
    end
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    linkStrobe = 1'b1; waitCyc(6);
    linkStrobe = 1'b0; waitCyc(6);
  endtask

  task automatic userTake();
    rxReady = 1'b1; waitCyc(1); rxReady = 1'b0; waitCyc(1);
  endtask

  task automatic userSend(logic [7:0] b);
    txData = b; txValid = 1'b1; waitCyc(1); txValid = 1'b0;
  endtask

  initial begin
    waitCyc(1);
    check("R1 reset rxValid", rxValid, 0);
    check("R1 reset fpgaValid", fpgaValid, 0);
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    check("R1 rxValid", rxValid, 0);
    check("R1 fpgaValid", fpgaValid, 0);
    check("R1 fpgaReady", fpgaReady, 1);
    check("R1 txReady", txReady, 1);

    // R2 timing and capture
    linkDataIn = 8'hA5; hostValid = 1'b1; linkStrobe = 1'b1;
    waitCyc(2);
    check("R2 not yet after two edges", rxValid, 0);
    waitCyc(1);
    check("R2 valid after three edges", rxValid, 1);
    check("R2 data", rxData, 8'hA5);
    waitCyc(3); linkStrobe = 1'b0; waitCyc(6);

    // R3 no overwrite while unread
    linkDataIn = 8'h3C; pulse();
    check("R3 fpgaReady low", fpgaReady, 0);
    check("R3 data held", rxData, 8'hA5);

    // R4 user drain
    rxReady = 1'b1; waitCyc(1); rxReady = 1'b0;
    check("R4 rxValid cleared", rxValid, 0);
    check("R4 fpgaReady back", fpgaReady, 1);
    waitCyc(2);

    // R5 no capture without host valid
    hostValid = 1'b0; linkDataIn = 8'h77; pulse();
    check("R5 no capture", rxValid, 0);

    // R9 held strobe acts once, falling edge nothing
    hostValid = 1'b1; linkDataIn = 8'h11; linkStrobe = 1'b1; waitCyc(8);
    check("R9 captured once", rxData, 8'h11);
    userTake(); waitCyc(8);
    check("R9 no repeat while high", rxValid, 0);
    linkStrobe = 1'b0; waitCyc(8);
    check("R9 falling edge ignored", rxValid, 0);
    hostValid = 1'b0;

    // R6 user load and hold
    userSend(8'hC3);
    check("R6 fpgaValid", fpgaValid, 1);
    check("R6 linkDataOut", linkDataOut, 8'hC3);
    check("R6 txReady low", txReady, 0);
    userSend(8'h99);
    check("R6 ignored while full", linkDataOut, 8'hC3);

    // R8 no release without host ready
    hostReady = 1'b0; pulse();
    check("R8 fpgaValid held", fpgaValid, 1);
    check("R8 data held", linkDataOut, 8'hC3);

    // R7 release with host ready, timing
    hostReady = 1'b1; linkStrobe = 1'b1;
    waitCyc(2);
    check("R7 still valid after two edges", fpgaValid, 1);
    waitCyc(1);
    check("R7 released after three edges", fpgaValid, 0);
    check("R7 txReady back", txReady, 1);
    waitCyc(3); linkStrobe = 1'b0; hostReady = 1'b0; waitCyc(6);

    // R10 full duplex on one edge
    userSend(8'h5A);
    linkDataIn = 8'h81; hostValid = 1'b1; hostReady = 1'b1; pulse();
    check("R10 inbound captured", rxData, 8'h81);
    check("R10 inbound valid", rxValid, 1);
    check("R10 outbound released", fpgaValid, 0);
    hostValid = 1'b0; hostReady = 1'b0;
    userTake();

    // R11 link reset
    userSend(8'hE7);
    linkDataIn = 8'h42; hostValid = 1'b1; pulse(); hostValid = 1'b0;
    check("R11 pre rxValid", rxValid, 1);
    linkReset = 1'b1; waitCyc(2);
    check("R11 fpgaReady low at second edge", fpgaReady, 0);
    check("R11 txReady low at second edge", txReady, 0);
    waitCyc(2);
    check("R11 rxValid cleared", rxValid, 0);
    check("R11 fpgaValid cleared", fpgaValid, 0);
    linkReset = 1'b0; waitCyc(4);
    check("R11 fpgaReady after", fpgaReady, 1);
    check("R11 txReady after", txReady, 1);

    waitCyc(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule